// File: doc/BRIEF.md
# Split-Register GPIO with Edge Interrupts

A 32-pin general-purpose I/O block for a peripheral bus whose data path is 16 bits wide per register. Every 32-bit state word (output drive, input level, falling-edge enable, rising-edge enable, interrupt status) is reached as two 16-bit halves. The low halves sit in one offset bank and the high halves in a second bank 0x500 above it. Inputs are synchronised and then checked for edges. A qualifying edge raises a level interrupt and overwrites the status word with the mask of that single pin.

Besides the plain pin functions, the block drives two lines that a separate serial bus engine uses: data and clock, taken from fixed output bits. It also turns a six-bit panel backlight code into a 3-bit level. Three bits of that code come from output bits [18:16] and three from a small enable register. The mapping between code and level is irregular.

Top module: `gpio_split_edge`

## Requirements
- R1: After reset the input word reads all ones. The output, falling-enable, rising-enable and status words read zero. The interrupt is low, and the backlight level is 7 because the all-zero code falls into the default entry.
- R2: A write to a low-half offset replaces bits [15:0] of the 32-bit word from wdata[15:0] and keeps bits [31:16]. A write to a high-half offset replaces bits [31:16] from wdata[15:0]. A read returns the selected half in rdata[15:0], and rdata[31:16] is zero.
- R3: The low-half byte offsets are: output 0x00C, input 0x010, falling enable 0x014, rising enable 0x018 and status 0x020. Each high half is at the same offset plus 0x500. The output word drives pins_out directly.
- R4: Each input passes through two flip-flops before it is used. A pin change is visible in the input word, and can cause an interrupt, on the second rising clock edge after the change.
- R5: A pin that rises while its rising-enable bit is 1, or falls while its falling-enable bit is 1, sets the interrupt. In the same edge it overwrites the status word with only that pin's bit. An edge whose direction is not enabled leaves both the interrupt and the status word unchanged.
- R6: When several enabled edges arrive in the same cycle, the status word records only the lowest-numbered of those pins.
- R7: Any write to either status half clears the interrupt and leaves the status word unchanged. If a qualifying edge arrives in the same cycle as that write, the interrupt stays set and the status word takes the new pin.
- R8: The backlight-enable register at offset 0x508 keeps only wdata[2:0] and reads back those three bits alone.
- R9: The backlight code has output bits [18:16] as its upper three bits and the enable bits as its lower three. The code maps to a level as follows: 0x07 gives 0, 0x10 gives 1, 0x11 gives 2, 0x20 gives 3, 0x0E gives 4, 0x15 gives 5 and 0x23 gives 6. Every other code gives 7.
- R10: Output bit 29 drives the serial data line and output bit 30 drives the serial clock line. Only a write to the high output half can change them.
- R11: Any other offset reads zero. Writes to the input halves and to undecoded offsets have no effect. The status word cannot be written with data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data; bits [15:0] are used (bits [2:0] at the backlight register) |
| rdata | output | 32 | Read data for addr, combinational |
| pins_in | input | 32 | Asynchronous input pins |
| pins_out | output | 32 | Output word |
| irq | output | 1 | Level interrupt |
| bl_level | output | 3 | Decoded backlight level |
| ser_data | output | 1 | Serial data line (output bit 29) |
| ser_clk | output | 1 | Serial clock line (output bit 30) |

## Verification
Two things can fall in the same cycle: clearing the interrupt through a status write, and the arrival of a new qualifying edge. The bench changes an enabled pin one cycle before it raises the status write strobe, so that the synchronised edge and the write meet at the same clock edge. After that edge the interrupt must still be high and the status word must hold the new pin. A second case has two enabled pins falling together, and only the lower-numbered pin may appear in status.

// File: rtl/gpio_split_pkg.sv
package gpio_split_pkg;
  localparam logic [11:0] OFS_OUT    = 12'h00C;
  localparam logic [11:0] OFS_IN     = 12'h010;
  localparam logic [11:0] OFS_FALL   = 12'h014;
  localparam logic [11:0] OFS_RISE   = 12'h018;
  localparam logic [11:0] OFS_STAT   = 12'h020;
  localparam logic [11:0] OFS_HIBANK = 12'h500;
  localparam logic [11:0] OFS_BLEN   = 12'h508;

  localparam int NUM_CFG = 3;
  typedef enum logic [1:0] {CFG_OUT = 2'd0, CFG_FALL = 2'd1, CFG_RISE = 2'd2} cfg_sel_e;

  function automatic logic [11:0] cfg_offset(input int k);
    case (k)
      0:       cfg_offset = OFS_OUT;
      1:       cfg_offset = OFS_FALL;
      default: cfg_offset = OFS_RISE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_half_reg.sv
module gpio_half_reg #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_lo,
  input  logic           wr_hi,
  input  logic [W/2-1:0] wval,
  output logic [W-1:0]   q
);
  localparam int H = W / 2;
  logic [W-1:0] d;
  logic         en;

  always_comb begin
    d  = q;
    en = wr_lo | wr_hi;
    if (wr_lo) d[H-1:0] = wval;
    if (wr_hi) d[W-1:H] = wval;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_in,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] level,
  output logic         evt_any,
  output logic [W-1:0] evt_first
);
  logic [W-1:0] meta_q;
  logic [W-1:0] evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '1;
      level  <= '1;
    end else begin
      meta_q <= pins_in;
      level  <= meta_q;
    end
  end

  always_comb begin
    evt       = (meta_q & ~level & rise_en) | (~meta_q & level & fall_en);
    evt_any   = |evt;
    evt_first = evt & (~evt + W'(1));
  end
endmodule

// File: rtl/gpio_bl_decode.sv
module gpio_bl_decode (
  input  logic [5:0] code,
  output logic [2:0] lvl
);
  always_comb begin
    case (code)
      6'b000_111: lvl = 3'd0;
      6'b010_000: lvl = 3'd1;
      6'b010_001: lvl = 3'd2;
      6'b100_000: lvl = 3'd3;
      6'b001_110: lvl = 3'd4;
      6'b010_101: lvl = 3'd5;
      6'b100_011: lvl = 3'd6;
      default:    lvl = 3'd7;
    endcase
  end
endmodule

// File: rtl/gpio_split_edge.sv
module gpio_split_edge
  import gpio_split_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int BUS_W   = 32,
  parameter int SDA_BIT = 29,
  parameter int SCL_BIT = 30,
  parameter int BL_LSB  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [11:0]      addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata,
  input  logic [NPINS-1:0] pins_in,
  output logic [NPINS-1:0] pins_out,
  output logic             irq,
  output logic [2:0]       bl_level,
  output logic             ser_data,
  output logic             ser_clk
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] cfg_q [NUM_CFG];
  logic [NPINS-1:0] in_level, evt_first;
  logic             evt_any;
  logic [NPINS-1:0] stat_q, stat_d;
  logic             irq_q, irq_d, stat_clr;
  logic [2:0]       blen_q, blen_d;
  logic             blen_we;

  for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
    gpio_half_reg #(.W(NPINS)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_lo (wr_en && addr == cfg_offset(k)),
      .wr_hi (wr_en && addr == (cfg_offset(k) + OFS_HIBANK)),
      .wval  (wdata[HALF-1:0]),
      .q     (cfg_q[k])
    );
  end

  gpio_edge_capture #(.W(NPINS)) u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pins_in   (pins_in),
    .rise_en   (cfg_q[CFG_RISE]),
    .fall_en   (cfg_q[CFG_FALL]),
    .level     (in_level),
    .evt_any   (evt_any),
    .evt_first (evt_first)
  );

  gpio_bl_decode u_bl (
    .code ({pins_out[BL_LSB+2:BL_LSB], blen_q}),
    .lvl  (bl_level)
  );

  // next state
  always_comb begin
    stat_clr = wr_en && (addr == OFS_STAT || addr == (OFS_STAT + OFS_HIBANK));
    blen_we  = wr_en && addr == OFS_BLEN;
    blen_d   = wdata[2:0];
    stat_d   = evt_any ? evt_first : stat_q;
    irq_d    = evt_any ? 1'b1 : (stat_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
      blen_q <= '0;
    end else begin
      if (evt_any) stat_q <= stat_d;
      irq_q <= irq_d;
      if (blen_we) blen_q <= blen_d;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (addr)
      OFS_OUT:                 rdata[HALF-1:0] = cfg_q[CFG_OUT][HALF-1:0];
      OFS_OUT  + OFS_HIBANK:   rdata[HALF-1:0] = cfg_q[CFG_OUT][NPINS-1:HALF];
      OFS_IN:                  rdata[HALF-1:0] = in_level[HALF-1:0];
      OFS_IN   + OFS_HIBANK:   rdata[HALF-1:0] = in_level[NPINS-1:HALF];
      OFS_FALL:                rdata[HALF-1:0] = cfg_q[CFG_FALL][HALF-1:0];
      OFS_FALL + OFS_HIBANK:   rdata[HALF-1:0] = cfg_q[CFG_FALL][NPINS-1:HALF];
      OFS_RISE:                rdata[HALF-1:0] = cfg_q[CFG_RISE][HALF-1:0];
      OFS_RISE + OFS_HIBANK:   rdata[HALF-1:0] = cfg_q[CFG_RISE][NPINS-1:HALF];
      OFS_STAT:                rdata[HALF-1:0] = stat_q[HALF-1:0];
      OFS_STAT + OFS_HIBANK:   rdata[HALF-1:0] = stat_q[NPINS-1:HALF];
      OFS_BLEN:                rdata[2:0]      = blen_q;
      default:                 rdata = '0;
    endcase
  end

  assign pins_out = cfg_q[CFG_OUT];
  assign irq      = irq_q;
  assign ser_data = cfg_q[CFG_OUT][SDA_BIT];
  assign ser_clk  = cfg_q[CFG_OUT][SCL_BIT];
endmodule

// File: rtl/gpio_split_edge_chk.sv
module gpio_split_edge_chk
  import gpio_split_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [11:0]      addr,
  input logic [NPINS-1:0] pins_out,
  input logic             irq,
  input logic [2:0]       bl_level,
  input logic             ser_data,
  input logic             ser_clk,
  input logic [NPINS-1:0] stat_q,
  input logic             evt_any
);
  localparam int HALF = NPINS / 2;

  AST_LOW_WRITE_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_OUT) |=> $stable(pins_out[NPINS-1:HALF])); // R2

  AST_STATUS_ONE_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stat_q)); // R5

  AST_EVENT_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    evt_any |=> irq); // R7

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == OFS_STAT || addr == (OFS_STAT + OFS_HIBANK)) && !evt_any) |=> !irq); // R7

  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == (OFS_OUT + OFS_HIBANK) || addr == OFS_BLEN)) |=> $stable(bl_level)); // R9

  AST_SERIAL_LINES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == (OFS_OUT + OFS_HIBANK)) |=> $stable({ser_data, ser_clk})); // R10
endmodule

bind gpio_split_edge gpio_split_edge_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .pins_out (pins_out),
  .irq      (irq),
  .bl_level (bl_level),
  .ser_data (ser_data),
  .ser_clk  (ser_clk),
  .stat_q   (stat_q),
  .evt_any  (evt_any)
);

// File: tb/gpio_split_edge_test.sv
module gpio_split_edge_test;
  localparam int PERIOD = 10;
  localparam logic [11:0] A_OUT = 12'h00C, A_IN = 12'h010, A_FALL = 12'h014,
                          A_RISE = 12'h018, A_STAT = 12'h020, HI = 12'h500, A_BLEN = 12'h508;
  // {out bits 18:16, enable bits 2:0, expected level}
  localparam logic [8:0] BL_VEC [0:9] = '{
    {3'd0, 3'd7, 3'd0}, {3'd2, 3'd0, 3'd1}, {3'd2, 3'd1, 3'd2}, {3'd4, 3'd0, 3'd3},
    {3'd1, 3'd6, 3'd4}, {3'd2, 3'd5, 3'd5}, {3'd4, 3'd3, 3'd6}, {3'd3, 3'd4, 3'd7},
    {3'd7, 3'd7, 3'd7}, {3'd0, 3'd0, 3'd7}};

  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata, pins_in = '1, pins_out;
  logic        irq, ser_data, ser_clk;
  logic [2:0]  bl_level;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] rv;

  gpio_split_edge uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pins_in(pins_in), .pins_out(pins_out), .irq(irq), .bl_level(bl_level),
    .ser_data(ser_data), .ser_clk(ser_clk));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; wr_en = 0; #1; d = rdata;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R1 reset state
    rd(A_IN, rv);      chk("R1 in lo", rv, 32'hFFFF);
    rd(A_IN + HI, rv); chk("R1 in hi", rv, 32'hFFFF);
    rd(A_OUT, rv);     chk("R1 out lo", rv, 0);
    rd(A_RISE + HI, rv); chk("R1 rise hi", rv, 0);
    rd(A_STAT, rv);    chk("R1 status", rv, 0);
    chk("R1 irq", irq, 0);
    chk("R1 level", bl_level, 7);

    // R9 table walk (R8 readback)
    foreach (BL_VEC[i]) begin
      wr(A_OUT + HI, {29'd0, BL_VEC[i][8:6]});
      wr(A_BLEN, {29'd0, BL_VEC[i][5:3]});
      #1 chk("R9 level", bl_level, {29'd0, BL_VEC[i][2:0]});
    end
    wr(A_BLEN, 32'hFFFF_FFF8);
    rd(A_BLEN, rv); chk("R8 blen keeps [2:0]", rv, 0);
    wr(A_BLEN, 32'h0000_00FD);
    rd(A_BLEN, rv); chk("R8 blen readback", rv, 32'h5);

    // R2/R3 halves
    wr(A_OUT, 32'h0000_1234);
    wr(A_OUT + HI, 32'h0000_ABCD);
    #1 chk("R3 pins_out", pins_out, 32'hABCD_1234);
    wr(A_OUT, 32'hFFFF_5678);
    #1 chk("R2 low keeps high", pins_out, 32'hABCD_5678);
    rd(A_OUT + HI, rv); chk("R2 read hi aligned", rv, 32'hABCD);
    wr(A_FALL + HI, 32'h0000_00F0);
    rd(A_FALL + HI, rv); chk("R2 fall hi", rv, 32'h00F0);
    rd(A_FALL, rv);      chk("R2 fall lo untouched", rv, 0);
    wr(A_FALL + HI, 32'h0);

    // R10 serial lines
    wr(A_OUT + HI, 32'h2000);
    #1 chk("R10 data/clk", {ser_data, ser_clk}, 2'b10);
    wr(A_OUT, 32'hFFFF);
    #1 chk("R10 low write no effect", {ser_data, ser_clk}, 2'b10);
    wr(A_OUT + HI, 32'h4000);
    #1 chk("R10 clk", {ser_data, ser_clk}, 2'b01);

    // R4/R5 falling edge on pin 3
    wr(A_FALL, 32'h0008);
    pins_in[3] = 0;
    rd(A_IN, rv); chk("R4 one flop not visible", rv, 32'hFFFF);
    chk("R4 no irq yet", irq, 0);
    rd(A_IN, rv); chk("R4 visible after two", rv, 32'hFFF7);
    chk("R5 irq set", irq, 1);
    rd(A_STAT, rv);      chk("R5 status lo", rv, 32'h0008);
    rd(A_STAT + HI, rv); chk("R5 status hi", rv, 0);
    // R7 clear keeps status
    wr(A_STAT, 32'hFFFF);
    #1 chk("R7 cleared", irq, 0);
    rd(A_STAT, rv); chk("R7 status kept", rv, 32'h0008);
    // R5 disabled direction ignored
    pins_in[3] = 1; tick(3);
    chk("R5 rise not enabled irq", irq, 0);
    rd(A_STAT, rv); chk("R5 rise not enabled status", rv, 32'h0008);
    // R5 high-half pin 20 rising
    wr(A_RISE + HI, 32'h0010);
    pins_in[20] = 0; tick(3);
    chk("R5 fall pin20 ignored", irq, 0);
    pins_in[20] = 1; tick(3);
    chk("R5 rise pin20 irq", irq, 1);
    rd(A_STAT + HI, rv); chk("R5 status hi pin20", rv, 32'h0010);
    rd(A_STAT, rv);      chk("R5 status lo cleared", rv, 0);
    wr(A_STAT + HI, 0);
    #1 chk("R7 clear via hi", irq, 0);

    // R6 two pins in the same cycle
    wr(A_FALL, 32'h0228);
    pins_in[5] = 0; pins_in[9] = 0; tick(3);
    rd(A_STAT, rv); chk("R6 lowest pin wins", rv, 32'h0020);
    chk("R6 irq", irq, 1);
    wr(A_STAT, 0);

    // R7 clear and new edge in the same cycle
    wr(A_RISE, 32'h0200);
    pins_in[9] = 1; pins_in[5] = 1;
    @(negedge clk); addr = A_STAT; wr_en = 1;
    @(negedge clk); wr_en = 0;
    #1 chk("R7 edge beats clear", irq, 1);
    rd(A_STAT, rv); chk("R7 status new pin", rv, 32'h0200);
    wr(A_STAT, 0);
    #1 chk("R7 later clear", irq, 0);

    // R11 undecoded and read-only
    wr(A_IN, 32'h0);
    rd(A_IN, rv);   chk("R11 input not writable", rv, 32'hFFFF);
    wr(A_STAT, 32'h0001);
    rd(A_STAT, rv); chk("R11 status not writable", rv, 32'h0200);
    wr(12'h004, 32'hFFFF);
    rd(12'h004, rv); chk("R11 undecoded 0x004", rv, 0);
    rd(12'h024, rv); chk("R11 undecoded 0x024", rv, 0);
    rd(12'h50C - 12'h008, rv); chk("R11 undecoded 0x504", rv, 0);
    chk("R11 outputs unchanged", pins_out, 32'h4000_FFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule